// File: doc/BRIEF.md
# Basic Block Integrity Checker

This block sits beside one processor core and checks, at run time, that each basic block of code retires the instruction words it was built with. The core reports every retired instruction, giving its word, its program counter and a kind code that marks it as a check instruction, a control-flow instruction or any other instruction. A check instruction opens a block. Its payload, the checksum computed when the program was built, is loaded into a reference register. Every later instruction of the block is folded into a running checksum. The closing control-flow instruction folds its own word in first, and the result is then compared with the reference. A mismatch, or a control-flow instruction that arrives while no block is open, raises a one-cycle violation pulse. The pulse comes with the failing instruction's program counter and a cause bit.

The reference, the running checksum and the open-block flag are all reachable through a small state port. A context switch or an interrupt handler can read them out and later write them back.

Top module: `bb_integrity_chk`

## Requirements
- R1: After reset the reference register, the running checksum and the open-block flag all read zero, and `viol_o` is low.
- R2: A retired check instruction (kind code 2'b01) loads `retire_word_i`, which carries its payload, into the reference register. It also clears the running checksum to zero and sets the open-block flag. Its own word is not folded into the checksum.
- R3: A retired instruction of kind 2'b00 or 2'b11 inside an open block updates the running checksum as new = rotate_left(old, 1) XOR word.
- R4: A retired instruction of kind 2'b00 or 2'b11 while no block is open leaves the running checksum unchanged.
- R5: A retired control-flow instruction (kind 2'b10) first folds its own word as in R3 and then compares the result with the reference. When the two are equal, no violation is raised. In every case the open-block flag and the running checksum are cleared afterwards.
- R6: When the compare of R5 fails, `viol_o` is high for exactly the one cycle after the control-flow instruction retires. In that cycle `viol_pc_o` holds its program counter and `viol_cause_o` is 0.
- R7: A control-flow instruction that retires while no block is open raises the pulse of R6 with `viol_cause_o` = 1. Two such instructions back to back give two consecutive pulses.
- R8: State port: `state_sel_i` 0 selects the reference, 1 the running checksum, and 2 a status word whose bit 0 is the open-block flag. `state_rdata_o` shows the selected item combinationally. A cycle with `state_we_i` high replaces the selected item with `state_wdata_i`.
- R9: When a state write and a retired instruction fall in the same cycle, the write wins for the selected item. The items that are not selected still update from the instruction.
- R10: A cycle with `retire_valid_i` low and no state write changes no state and raises no violation, whatever the other retire inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_kind_i | input | 2 | 00 other, 01 check, 10 control-flow, 11 other |
| retire_word_i | input | WORD_W | Instruction word; for a check instruction, its checksum payload |
| retire_pc_i | input | PC_W | Program counter of the retiring instruction |
| state_we_i | input | 1 | Write the selected state item |
| state_sel_i | input | 2 | 0 reference, 1 running checksum, 2 status |
| state_wdata_i | input | WORD_W | Write data |
| state_rdata_o | output | WORD_W | Selected state item |
| viol_o | output | 1 | One-cycle integrity violation pulse |
| viol_pc_o | output | PC_W | Program counter of the failing control-flow instruction |
| viol_cause_o | output | 1 | 0 checksum mismatch, 1 no open block |

## Verification
A corrupted running checksum stays hidden while a block is still executing. It shows up either when the checksum is read through the state port, or as a false or missing pulse one cycle after the block's closing control-flow instruction. An open-block flag stuck at the wrong value shows up at the next control-flow instruction, as a pulse with the wrong cause bit or as a pulse that should not occur. The bench therefore closes every block, reads the state back in the middle of blocks, and tracks each expected pulse with its program counter and cause, cycle by cycle.

// File: rtl/bbic_pkg.sv
package bbic_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_CHECK = 2'b01,
    KIND_CFI   = 2'b10,
    KIND_RSVD  = 2'b11
  } retire_kind_e;

  typedef enum logic [1:0] {
    SEL_REF  = 2'd0,
    SEL_INC  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } state_sel_e;

  localparam int unsigned CAUSE_MISMATCH = 0;
  localparam int unsigned CAUSE_NO_BLOCK = 1;

endpackage

// File: rtl/bbic_ref_reg.sv
module bbic_ref_reg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_fire_i,
  input  logic              cfi_fire_i,
  input  logic [WORD_W-1:0] chk_word_i,
  input  logic              wr_ref_i,
  input  logic              wr_stat_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              stat_wbit_i,
  output logic [WORD_W-1:0] ref_o,
  output logic              open_o
);

  logic [WORD_W-1:0] ref_q, ref_d;
  logic              open_q, open_d;

  always_comb begin
    ref_d = ref_q;
    if (wr_ref_i)        ref_d = wdata_i;
    else if (chk_fire_i) ref_d = chk_word_i;
  end

  always_comb begin
    open_d = open_q;
    if (wr_stat_i)       open_d = stat_wbit_i;
    else if (chk_fire_i) open_d = 1'b1;
    else if (cfi_fire_i) open_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      open_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      open_q <= open_d;
    end
  end

  assign ref_o  = ref_q;
  assign open_o = open_q;

endmodule

// File: rtl/bbic_hash_acc.sv
module bbic_hash_acc #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROT    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              fold_en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wr_inc_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] inc_o,
  output logic [WORD_W-1:0] fold_o
);

  localparam int unsigned R = ROT % WORD_W;

  logic [WORD_W-1:0] inc_q, inc_d, rot_w;

  generate
    if (R == 0) begin : g_norot
      assign rot_w = inc_q;
    end else begin : g_rot
      assign rot_w = {inc_q[WORD_W-1-R:0], inc_q[WORD_W-1 -: R]};
    end
  endgenerate

  assign fold_o = rot_w ^ word_i;

  always_comb begin
    inc_d = inc_q;
    if (wr_inc_i)       inc_d = wdata_i;
    else if (restart_i) inc_d = '0;
    else if (fold_en_i) inc_d = fold_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_q <= '0;
    else         inc_q <= inc_d;
  end

  assign inc_o = inc_q;

endmodule

// File: rtl/bbic_verdict.sv
module bbic_verdict #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfi_fire_i,
  input  logic              blk_open_i,
  input  logic [WORD_W-1:0] fold_i,
  input  logic [WORD_W-1:0] ref_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              viol_o,
  output logic [PC_W-1:0]   viol_pc_o,
  output logic              viol_cause_o
);

  logic            bad_w;
  logic            viol_q;
  logic [PC_W-1:0] pc_q;
  logic            cause_q;

  assign bad_w = cfi_fire_i && (!blk_open_i || (fold_i != ref_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q  <= 1'b0;
      pc_q    <= '0;
      cause_q <= 1'b0;
    end else begin
      viol_q <= bad_w;
      if (bad_w) begin
        pc_q    <= pc_i;
        cause_q <= !blk_open_i;
      end
    end
  end

  assign viol_o       = viol_q;
  assign viol_pc_o    = pc_q;
  assign viol_cause_o = cause_q;

endmodule

// File: rtl/bb_integrity_chk.sv
module bb_integrity_chk
  import bbic_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ROT    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_valid_i,
  input  logic [1:0]        retire_kind_i,
  input  logic [WORD_W-1:0] retire_word_i,
  input  logic [PC_W-1:0]   retire_pc_i,
  input  logic              state_we_i,
  input  logic [1:0]        state_sel_i,
  input  logic [WORD_W-1:0] state_wdata_i,
  output logic [WORD_W-1:0] state_rdata_o,
  output logic              viol_o,
  output logic [PC_W-1:0]   viol_pc_o,
  output logic              viol_cause_o
);

  logic chk_fire, cfi_fire, oth_fire;
  logic wr_ref, wr_inc, wr_stat;
  logic [WORD_W-1:0] ref_q, inc_q, fold_w;
  logic blk_open_q;

  assign chk_fire = retire_valid_i && (retire_kind_i == KIND_CHECK);
  assign cfi_fire = retire_valid_i && (retire_kind_i == KIND_CFI);
  assign oth_fire = retire_valid_i && blk_open_q &&
                    ((retire_kind_i == KIND_OTHER) || (retire_kind_i == KIND_RSVD));

  assign wr_ref  = state_we_i && (state_sel_i == SEL_REF);
  assign wr_inc  = state_we_i && (state_sel_i == SEL_INC);
  assign wr_stat = state_we_i && (state_sel_i == SEL_STAT);

  bbic_ref_reg #(.WORD_W(WORD_W)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chk_fire_i  (chk_fire),
    .cfi_fire_i  (cfi_fire),
    .chk_word_i  (retire_word_i),
    .wr_ref_i    (wr_ref),
    .wr_stat_i   (wr_stat),
    .wdata_i     (state_wdata_i),
    .stat_wbit_i (state_wdata_i[0]),
    .ref_o       (ref_q),
    .open_o      (blk_open_q)
  );

  bbic_hash_acc #(.WORD_W(WORD_W), .ROT(ROT)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (chk_fire || cfi_fire),
    .fold_en_i (oth_fire),
    .word_i    (retire_word_i),
    .wr_inc_i  (wr_inc),
    .wdata_i   (state_wdata_i),
    .inc_o     (inc_q),
    .fold_o    (fold_w)
  );

  bbic_verdict #(.WORD_W(WORD_W), .PC_W(PC_W)) u_verdict (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfi_fire_i   (cfi_fire),
    .blk_open_i   (blk_open_q),
    .fold_i       (fold_w),
    .ref_i        (ref_q),
    .pc_i         (retire_pc_i),
    .viol_o       (viol_o),
    .viol_pc_o    (viol_pc_o),
    .viol_cause_o (viol_cause_o)
  );

  always_comb begin
    unique case (state_sel_i)
      SEL_REF:  state_rdata_o = ref_q;
      SEL_INC:  state_rdata_o = inc_q;
      SEL_STAT: state_rdata_o = {{(WORD_W-1){1'b0}}, blk_open_q};
      default:  state_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/bbic_checker.sv
module bbic_checker
  import bbic_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PC_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_valid_i,
  input logic [1:0]        retire_kind_i,
  input logic [PC_W-1:0]   retire_pc_i,
  input logic              state_we_i,
  input logic              viol_o,
  input logic [PC_W-1:0]   viol_pc_o,
  input logic              viol_cause_o,
  input logic [WORD_W-1:0] ref_q,
  input logic [WORD_W-1:0] inc_q,
  input logic              blk_open_q
);

  assert_chk_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i && retire_kind_i == KIND_CHECK && !state_we_i
    |=> blk_open_q && inc_q == '0);

  assert_cfi_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i && retire_kind_i == KIND_CFI && !state_we_i
    |=> !blk_open_q && inc_q == '0);

  assert_viol_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(retire_valid_i && retire_kind_i == KIND_CFI));

  assert_viol_pc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> viol_pc_o == $past(retire_pc_i));

  assert_orphan_cfi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i && retire_kind_i == KIND_CFI && !blk_open_q
    |=> viol_o && viol_cause_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i && !state_we_i
    |=> $stable(ref_q) && $stable(inc_q) && $stable(blk_open_q) && !viol_o);

endmodule

bind bb_integrity_chk bbic_checker #(.WORD_W(WORD_W), .PC_W(PC_W)) u_bbic_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .retire_valid_i (retire_valid_i),
  .retire_kind_i  (retire_kind_i),
  .retire_pc_i    (retire_pc_i),
  .state_we_i     (state_we_i),
  .viol_o         (viol_o),
  .viol_pc_o      (viol_pc_o),
  .viol_cause_o   (viol_cause_o),
  .ref_q          (ref_q),
  .inc_q          (inc_q),
  .blk_open_q     (blk_open_q)
);

// File: tb/bb_integrity_chk_tb.sv
module bb_integrity_chk_tb;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rv = 1'b0;
  logic [1:0]    rk = 2'b00;
  logic [W-1:0]  rw = '0;
  logic [W-1:0]  rpc = '0;
  logic          swe = 1'b0;
  logic [1:0]    ssel = 2'd0;
  logic [W-1:0]  swd = '0;
  logic [W-1:0]  srd;
  logic          viol;
  logic [W-1:0]  vpc;
  logic          vcause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected violation: {cause, pc}
  logic [W:0] exp_q[$];

  // reference model state
  logic [W-1:0] m_ref = '0, m_inc = '0;
  logic         m_open = 1'b0;

  always #5 clk = ~clk;

  bb_integrity_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .retire_valid_i(rv), .retire_kind_i(rk), .retire_word_i(rw), .retire_pc_i(rpc),
    .state_we_i(swe), .state_sel_i(ssel), .state_wdata_i(swd), .state_rdata_o(srd),
    .viol_o(viol), .viol_pc_o(vpc), .viol_cause_o(vcause)
  );

  function automatic logic [W-1:0] fold(input logic [W-1:0] acc, input logic [W-1:0] w);
    return {acc[W-2:0], acc[W-1]} ^ w;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && viol) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6/R7: unexpected pulse pc=%h cause=%0d expected none", vpc, vcause);
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        if ({vcause, vpc} !== e) begin
          n_fail++;
          $display("FAIL R6/R7: pulse got cause=%0d pc=%h expected cause=%0d pc=%h",
                   vcause, vpc, e[W], e[W-1:0]);
        end
      end
    end
  end

  task automatic retire(input logic [1:0] k, input logic [W-1:0] w, input logic [W-1:0] pc);
    @(negedge clk);
    rv = 1'b1; rk = k; rw = w; rpc = pc;
    case (k)
      2'b01: begin m_ref = w; m_inc = '0; m_open = 1'b1; end
      2'b10: begin
        if (!m_open) exp_q.push_back({1'b1, pc});
        else if (fold(m_inc, w) != m_ref) exp_q.push_back({1'b0, pc});
        m_open = 1'b0; m_inc = '0;
      end
      default: if (m_open) m_inc = fold(m_inc, w);
    endcase
    @(posedge clk); #1;
    rv = 1'b0;
  endtask

  task automatic state_write(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    swe = 1'b1; ssel = sel; swd = d;
    @(posedge clk); #1;
    swe = 1'b0;
    case (sel)
      2'd0: m_ref = d;
      2'd1: m_inc = d;
      2'd2: m_open = d[0];
      default: ;
    endcase
  endtask

  task automatic check_state(input logic [1:0] sel, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    ssel = sel; #1;
    n_chk++;
    if (srd !== exp) begin
      n_fail++;
      $display("FAIL %s: state sel=%0d got %h expected %h", req, sel, srd, exp);
    end
  endtask

  task automatic check_model(input string req);
    check_state(2'd0, m_ref, req);
    check_state(2'd1, m_inc, req);
    check_state(2'd2, {31'd0, m_open}, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : main
    fork
      begin : stim
        logic [W-1:0] ck;
        logic [W-1:0] sv_ref, sv_inc, sv_stat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_state(2'd0, '0, "R1");
        check_state(2'd1, '0, "R1");
        check_state(2'd2, '0, "R1");
        n_chk++;
        if (viol !== 1'b0) begin n_fail++; $display("FAIL R1: viol=%b expected 0", viol); end

        // R2/R3/R5: good block
        ck = '0;
        ck = fold(ck, 32'h1111_0001); ck = fold(ck, 32'h8000_0002);
        ck = fold(ck, 32'hDEAD_BEEF); ck = fold(ck, 32'h0BAD_F00D);
        retire(2'b01, ck, 32'h100);
        check_model("R2");
        retire(2'b00, 32'h1111_0001, 32'h104);
        retire(2'b11, 32'h8000_0002, 32'h108);
        check_state(2'd1, fold(fold(32'h0, 32'h1111_0001), 32'h8000_0002), "R3");
        retire(2'b00, 32'hDEAD_BEEF, 32'h10C);
        retire(2'b10, 32'h0BAD_F00D, 32'h110);
        idle(2);
        check_model("R5");

        // R6 mismatch
        retire(2'b01, 32'h1234_5678, 32'h200);
        retire(2'b00, 32'hAAAA_5555, 32'h204);
        retire(2'b10, 32'h0000_0001, 32'h208);
        idle(2);
        check_model("R6");

        // R4 outside block ignored, then R7 orphan
        retire(2'b00, 32'hFFFF_0000, 32'h300);
        check_state(2'd1, '0, "R4");
        retire(2'b10, 32'h5, 32'h304);
        // R7 back-to-back orphans
        retire(2'b10, 32'h6, 32'h308);
        retire(2'b10, 32'h7, 32'h30C);
        idle(2);

        // R10 valid low with live-looking inputs
        retire(2'b01, 32'h0000_00FF, 32'h400);
        retire(2'b00, 32'h0000_0F0F, 32'h404);
        @(negedge clk); rv = 1'b0; rk = 2'b10; rw = 32'hFFFF_FFFF; rpc = 32'h999;
        @(negedge clk); rk = 2'b01;
        @(negedge clk);
        check_model("R10");

        // R8 save / restore around a context switch
        sv_ref = m_ref; sv_inc = m_inc; sv_stat = {31'd0, m_open};
        check_state(2'd0, sv_ref, "R8");
        retire(2'b01, 32'hCAFE_0000, 32'h500);
        retire(2'b00, 32'h0000_0003, 32'h504);
        retire(2'b10, 32'h1, 32'h508);   // mismatch in handler
        idle(2);
        state_write(2'd0, sv_ref);
        state_write(2'd1, sv_inc);
        state_write(2'd2, sv_stat);
        check_model("R8");
        // finish the restored block correctly: fold 0xF0 then cfi
        ck = fold(m_inc, 32'h0000_00F0);
        retire(2'b00, 32'h0000_00F0, 32'h408);
        retire(2'b10, m_ref ^ {ck[W-2:0], ck[W-1]}, 32'h40C);
        idle(2);

        // R9 write priority over check load
        @(negedge clk);
        rv = 1'b1; rk = 2'b01; rw = 32'h7777_7777; rpc = 32'h600;
        swe = 1'b1; ssel = 2'd0; swd = 32'h3333_3333;
        @(posedge clk); #1;
        rv = 1'b0; swe = 1'b0;
        m_ref = 32'h3333_3333; m_inc = '0; m_open = 1'b1;
        check_model("R9");
        // R9 stat write beats cfi close; inc still cleared by cfi
        retire(2'b00, 32'h10, 32'h604);
        @(negedge clk);
        rv = 1'b1; rk = 2'b10; rw = 32'h0; rpc = 32'h608;
        swe = 1'b1; ssel = 2'd2; swd = 32'h1;
        exp_q.push_back({1'b0, 32'h608});
        @(posedge clk); #1;
        rv = 1'b0; swe = 1'b0;
        m_open = 1'b1; m_inc = '0;
        check_model("R9");
        idle(3);
        n_chk++;
        if (exp_q.size() != 0) begin
          n_fail++;
          $display("FAIL R6: %0d pulses missing expected 0", exp_q.size());
        end
        done = 1'b1;
      end
      begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule